// File: doc/BRIEF.md
# Sensor Pixel Capture with Frame-Buffer Decimation

This block sits in the pixel-clock domain of a parallel CMOS image sensor. It accepts one byte per clock on an 8-bit bus while the line-valid strobe is high. It pairs consecutive accepted bytes into a 16-bit RGB565 pixel and narrows that pixel to 12-bit RGB444. For every completed pixel it issues one write toward a frame buffer.

A 19-bit linear pixel counter is large enough for a 640x480 frame. It restarts whenever frame-sync is asserted. The counter value is mapped onto a 17-bit buffer address, which indexes a buffer of 131072 entries. The mapping depends on the two resolution-select inputs. At full resolution the two low counter bits are dropped, so four neighbouring pixels land in one buffer slot. In either reduced mode the low 17 counter bits are used directly.

The write side is a valid-only stream with no ready input. A sensor cannot be stalled, so there is no back-pressure. The sink must take the 12-bit pixel and its address in every cycle in which the valid strobe is high. Each write is valid for exactly one cycle.

Top module: `cam_pixel_capture`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, `wr_valid` is 0, `wr_addr` is 0 and `wr_pixel` is 0.
- R2: The accepted bytes alternate between first byte and second byte. `wr_valid` is high for exactly the one cycle after the clock edge that accepts a second byte. It is never high in two consecutive cycles.
- R3: The first byte carries {R[4:0], G[5:3]} and the second byte carries {G[2:0], B[4:0]}. `wr_pixel[11:8]` = R[4:1], `wr_pixel[7:4]` = G[5:2] and `wr_pixel[3:0]` = B[4:1].
- R4: A byte is accepted only on an edge where `line_valid` is 1. Bytes presented while `line_valid` is 0 produce no write and do not disturb a half-collected pixel.
- R5: An edge with `frame_sync` high clears the pixel counter to 0 and returns the byte phase to "first byte". No write follows that edge.
- R6: The pixel counter advances by one after each completed pixel. The first pixel after a frame-sync uses counter value 0.
- R7: With `sel_small` = 0 and `sel_half` = 0 (640x480), `wr_addr` equals the pixel counter bits [18:2], so pixels 4k to 4k+3 all write address k.
- R8: With `sel_half` = 1 (320x240), `wr_addr` equals the pixel counter bits [16:0].
- R9: With `sel_small` = 1 (160x120), `wr_addr` equals the pixel counter bits [16:0]. When both selects are 1, the 160x120 mode takes priority, and the mapping is also direct.
- R10: When `frame_sync` and `line_valid` are both high on the same edge, the byte is not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sensor pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cam_data | input | 8 | Sensor byte bus |
| line_valid | input | 1 | Byte qualifier, high during active line data |
| frame_sync | input | 1 | Frame start; clears counter and byte phase |
| sel_small | input | 1 | Selects 160x120 direct addressing (has priority) |
| sel_half | input | 1 | Selects 320x240 direct addressing |
| wr_valid | output | 1 | One-cycle write strobe for the frame buffer |
| wr_addr | output | 17 | Frame-buffer write address |
| wr_pixel | output | 12 | RGB444 pixel to write |

## Verification
The checker watches four things on every cycle: the single-cycle shape of the write strobe, the absence of writes after frame-sync or after idle bytes, the requirement that a write is preceded by an accepted byte, and the bit packing of the pixel from the two bytes that preceded it. The address mapping cannot be seen at the ports on a cycle-by-cycle basis, because it depends on the internal counter. Only the directed scenarios show it, by counting pixels after a frame-sync in each resolution mode. The same applies to clearing of a half-collected pixel by frame-sync and to the frame-sync-over-line-valid priority. Upper-bit truncation past 131072 pixels is not reached within the run length.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

  localparam int unsigned RGB565_W = 16;
  localparam int unsigned RGB444_W = 12;

  typedef struct packed {
    logic [3:0] red;
    logic [3:0] grn;
    logic [3:0] blu;
  } rgb444_t;

  // Keep the top bits of each colour channel of a 5-6-5 word.
  function automatic rgb444_t narrow_565(input logic [RGB565_W-1:0] w);
    rgb444_t o;
    o.red = w[15:12];
    o.grn = w[10:7];
    o.blu = w[4:1];
    return o;
  endfunction

endpackage

// File: rtl/cap_byte_pair.sv
module cap_byte_pair #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] byte_in,
  output logic              pair_done,
  output logic [2*DATA_W-1:0] pair_word
);

  logic              second_q;
  logic [DATA_W-1:0] first_q;
  logic              take;

  assign take      = line_valid & ~frame_sync;
  assign pair_done = take & second_q;
  assign pair_word = {first_q, byte_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      first_q  <= '0;
    end else if (frame_sync) begin
      second_q <= 1'b0;
    end else if (take) begin
      second_q <= ~second_q;
      if (!second_q) first_q <= byte_in;
    end
  end

endmodule

// File: rtl/cap_pix_counter.sv
module cap_pix_counter #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= count + 1'b1;
  end

endmodule

// File: rtl/cap_addr_map.sv
module cap_addr_map #(
  parameter int unsigned PIX_W = 19,
  parameter int unsigned BUF_W = 17
) (
  input  logic [PIX_W-1:0] pix_addr,
  input  logic             direct,
  output logic [BUF_W-1:0] buf_addr
);

  localparam int unsigned DROP = PIX_W - BUF_W;

  generate
    if (DROP == 0) begin : g_same
      assign buf_addr = pix_addr;
    end else begin : g_decim
      logic [BUF_W-1:0] decim;
      logic [BUF_W-1:0] low;
      assign decim    = pix_addr[PIX_W-1:DROP];
      assign low      = pix_addr[BUF_W-1:0];
      assign buf_addr = direct ? low : decim;
    end
  endgenerate

endmodule

// File: rtl/cam_pixel_capture.sv
module cam_pixel_capture
  import cam_cap_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PIX_W  = 19,
  parameter int unsigned BUF_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cam_data,
  input  logic              line_valid,
  input  logic              frame_sync,
  input  logic              sel_small,
  input  logic              sel_half,
  output logic              wr_valid,
  output logic [BUF_W-1:0]  wr_addr,
  output logic [RGB444_W-1:0] wr_pixel
);

  localparam int unsigned WORD_W = 2 * DATA_W;

  logic              pair_done;
  logic [WORD_W-1:0] pair_word;
  logic [PIX_W-1:0]  pix_cnt;
  logic [BUF_W-1:0]  buf_addr;
  logic              direct;

  // 160x120 has priority; both reduced modes address directly.
  assign direct = sel_small | sel_half;

  cap_byte_pair #(.DATA_W(DATA_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .line_valid(line_valid), .byte_in(cam_data),
    .pair_done(pair_done), .pair_word(pair_word)
  );

  cap_pix_counter #(.CNT_W(PIX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(frame_sync),
    .step(pair_done), .count(pix_cnt)
  );

  cap_addr_map #(.PIX_W(PIX_W), .BUF_W(BUF_W)) u_map (
    .pix_addr(pix_cnt), .direct(direct), .buf_addr(buf_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_pixel <= '0;
    end else begin
      wr_valid <= pair_done;
      if (pair_done) begin
        wr_addr  <= buf_addr;
        wr_pixel <= narrow_565(pair_word);
      end
    end
  end

endmodule

// File: rtl/cam_pixel_capture_chk.sv
module cam_pixel_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cam_data,
  input logic        line_valid,
  input logic        frame_sync,
  input logic        wr_valid,
  input logic [11:0] wr_pixel
);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R2

  AST_WRITE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(line_valid) && !$past(frame_sync))); // R4

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_valid && !frame_sync) |=> !wr_valid); // R4

  AST_SYNC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> !wr_valid); // R5

  AST_PIXEL_PACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && age == 2'd3 && $past(line_valid, 2) && !$past(frame_sync, 2))
    |-> wr_pixel == {$past(cam_data[7:4], 2), $past(cam_data[2:0], 2),
                     $past(cam_data[7]), $past(cam_data[4:1])}); // R3

endmodule

bind cam_pixel_capture cam_pixel_capture_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cam_data(cam_data), .line_valid(line_valid),
  .frame_sync(frame_sync), .wr_valid(wr_valid), .wr_pixel(wr_pixel)
);

// File: tb/test_cam_pixel_capture.sv
module test_cam_pixel_capture;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cam_data = '0;
  logic        line_valid = 1'b0;
  logic        frame_sync = 1'b0;
  logic        sel_small = 1'b0;
  logic        sel_half = 1'b0;
  logic        wr_valid;
  logic [16:0] wr_addr;
  logic [11:0] wr_pixel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cam_pixel_capture i_cam_pixel_capture (
    .clk(clk), .rst_n(rst_n), .cam_data(cam_data), .line_valid(line_valid),
    .frame_sync(frame_sync), .sel_small(sel_small), .sel_half(sel_half),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_pixel(wr_pixel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One clock: inputs set at the falling edge, outputs read 1 ns after rising.
  task automatic cyc(input logic [7:0] d, input logic lv, input logic fs);
    @(negedge clk);
    cam_data = d; line_valid = lv; frame_sync = fs;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] mk565(input int r, input int g, input int b);
    return {r[4:0], g[5:0], b[4:0]};
  endfunction

  function automatic logic [11:0] exp444(input int r, input int g, input int b);
    logic [4:0] r5 = r[4:0];
    logic [5:0] g6 = g[5:0];
    logic [4:0] b5 = b[4:0];
    return {r5[4:1], g6[5:2], b5[4:1]};
  endfunction

  // Sends one pixel back to back, checks the write.
  task automatic send_pix(input string req, input int r, input int g, input int b,
                          input int exp_addr);
    logic [15:0] w = mk565(r, g, b);
    cyc(w[15:8], 1'b1, 1'b0);
    check({req, " no write after first byte"}, wr_valid, 0);
    cyc(w[7:0], 1'b1, 1'b0);
    check({req, " write strobe"}, wr_valid, 1);
    check({req, " pixel"}, wr_pixel, exp444(r, g, b));
    check({req, " address"}, wr_addr, exp_addr);
  endtask

  task automatic fsync();
    cyc(8'h00, 1'b0, 1'b1);
    check("R5 no write on sync", wr_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) cyc(8'hFF, 1'b0, 1'b0);
    check("R1 valid in reset", wr_valid, 0);
    check("R1 addr in reset", wr_addr, 0);
    check("R1 pixel in reset", wr_pixel, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 valid after release", wr_valid, 0);
    check("R1 pixel after release", wr_pixel, 0);
  endtask

  task automatic t_pack();
    sel_half = 1'b1;
    fsync();
    send_pix("R3 all ones", 31, 63, 31, 0);
    cyc(8'h00, 1'b0, 1'b0);
    check("R2 strobe one cycle", wr_valid, 0);
    send_pix("R3 red only", 31, 0, 0, 1);
    send_pix("R3 green only", 0, 63, 0, 2);
    send_pix("R3 blue only", 0, 0, 31, 3);
    send_pix("R3 mixed", 5'b10110, 6'b101001, 5'b01101, 4);
    send_pix("R3 low bits dropped", 1, 3, 1, 5);
    sel_half = 1'b0;
  endtask

  task automatic t_gap();
    logic [15:0] w = mk565(19, 44, 7);
    sel_half = 1'b1;
    fsync();
    cyc(w[15:8], 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cyc(8'hA5 ^ 8'(i), 1'b0, 1'b0);
      check("R4 idle byte no write", wr_valid, 0);
    end
    cyc(w[7:0], 1'b1, 1'b0);
    check("R4 write after gap", wr_valid, 1);
    check("R4 pixel across gap", wr_pixel, exp444(19, 44, 7));
    check("R6 first pixel address", wr_addr, 0);
    sel_half = 1'b0;
  endtask

  task automatic t_sync_clear();
    sel_half = 1'b1;
    fsync();
    send_pix("R6 step0", 1, 2, 3, 0);
    send_pix("R6 step1", 4, 5, 6, 1);
    send_pix("R6 step2", 7, 8, 9, 2);
    cyc(8'hFF, 1'b1, 1'b0);          // half pixel, then sync
    fsync();
    send_pix("R5 phase and addr cleared", 10, 20, 30, 0);
    sel_half = 1'b0;
  endtask

  task automatic t_sync_priority();
    sel_half = 1'b1;
    fsync();
    cyc(8'hFF, 1'b1, 1'b1);          // byte with sync: not taken
    check("R10 no write", wr_valid, 0);
    send_pix("R10 pair after sync", 12, 34, 21, 0);
    sel_half = 1'b0;
  endtask

  task automatic t_full();
    sel_small = 1'b0; sel_half = 1'b0;
    fsync();
    for (int n = 0; n < 10; n++)
      send_pix("R7 decimated", n, 2 * n, 31 - n, n >> 2);
  endtask

  task automatic t_half();
    sel_small = 1'b0; sel_half = 1'b1;
    fsync();
    for (int n = 0; n < 6; n++)
      send_pix("R8 direct", 3 * n, n, n, n);
    sel_half = 1'b0;
  endtask

  task automatic t_small();
    sel_small = 1'b1; sel_half = 1'b0;
    fsync();
    for (int n = 0; n < 6; n++)
      send_pix("R9 direct", n, n, n, n);
    sel_half = 1'b1;
    fsync();
    for (int n = 0; n < 5; n++)
      send_pix("R9 both selects", n, 1, 2, n);
    sel_small = 1'b0; sel_half = 1'b0;
  endtask

  initial begin
    t_reset();
    t_pack();
    t_gap();
    t_sync_clear();
    t_sync_priority();
    t_full();
    t_half();
    t_small();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule